// File: doc/BRIEF.md
# Line-Rate Keyboard Line Sampler with Receive Window

This block watches the two wires of a PS/2 keyboard port at the video line rate. On every line tick it takes one sample of the clock wire and one of the data wire, shifts each into its own short history, and after a fixed number of lines it hands out a packed byte that holds both histories. Decoding frames from these histories is left to downstream logic.

The keyboard is only allowed to talk during receive windows. A window opens on every Nth field tick, with N chosen by a rate select input: 4 for a 60 Hz field rate and 5 for a 75 Hz field rate. Either choice gives roughly fifteen windows a second. A window stays open for a fixed number of line ticks. At all other times the block pulls the keyboard clock low through an open-drain enable, so the device holds its bytes in its own buffer until the next window.

Top module: `kbd_line_sampler`

## Requirements
- R1: During and directly after reset, `kbd_clk_pull_low` is 1, `pack_valid` is 0 and `pack_byte` is 0.
- R2: `kbd_clk_pull_low` is the inverse of the window state. It is 1 whenever no window is open. It goes to 0 in the cycle after a `field_tick` that opens a window.
- R3: With `rate_75` = 0, the field divider counts modulo 4. Counting from reset, the 1st, 5th, 9th and so on field ticks open a window.
- R4: With `rate_75` = 1, the field divider counts modulo 5. It keeps its current count when `rate_75` changes, and wraps to 0 when its count reaches the limit minus one. A field tick that finds the count at 0 opens a window.
- R5: A window closes after exactly WIN_LINES line ticks received while it is open. `kbd_clk_pull_low` returns to 1 in the cycle after the last of those ticks.
- R6: On every `line_tick`, one clock sample and one data sample are shifted in. `pack_byte[7:4]` holds the 4 most recent clock samples and `pack_byte[3:0]` holds the 4 most recent data samples. The oldest sample sits in bit 7 (clock) and bit 3 (data); the newest sits in bit 4 and bit 0. A sample is the level held on the wire for at least 3 cycles before the tick.
- R7: `pack_valid` pulses for one cycle, in the cycle after every 4th line tick counted from the start of a window. `pack_byte` changes only together with `pack_valid`.
- R8: Line ticks that arrive while no window is open never produce `pack_valid`.
- R9: A field tick that does not open a window leaves `kbd_clk_pull_low` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle pulse per video line |
| field_tick | input | 1 | One-cycle pulse per video field |
| rate_75 | input | 1 | 0: window every 4th field, 1: every 5th field |
| kbd_clk_in | input | 1 | Raw keyboard clock wire level |
| kbd_dat_in | input | 1 | Raw keyboard data wire level |
| pack_byte | output | 8 | Packed clock/data sample history |
| pack_valid | output | 1 | One-cycle strobe when a packed byte completes |
| kbd_clk_pull_low | output | 1 | Open-drain enable that pulls the keyboard clock low |

## Verification
The bench keeps the defaults for the sample count (4), the synchronizer depth (2) and the field divisors (4 and 5). It shortens WIN_LINES to 8, so a full window takes only eight line ticks and yields two packed bytes. With that setting the window closing, the behaviour of line ticks outside the window, and several wraps of both divisors, including a switch of rate while the count is mid-way, all fit into a short run. Sample patterns come from a bench-side shift-register generator, so the expected bytes are computed independently of the design.

// File: rtl/kls_pkg.sv
package kls_pkg;

   // field-rate selection as seen by the scheduler
   typedef enum logic {
      RATE_SLOW_FIELD = 1'b0,
      RATE_FAST_FIELD = 1'b1
   } kls_rate_e;

   // width helper that never returns zero
   function automatic int kls_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic int kls_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/kls_sync.sv
module kls_sync #(
   parameter int BITS   = 2,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [BITS-1:0] raw_i,
   output logic [BITS-1:0] sync_o
);

   initial begin
      assert (BITS >= 1) else $error("kls_sync: BITS must be at least 1");
      assert (STAGES >= 0) else $error("kls_sync: STAGES must not be negative");
   end

   generate
      if (STAGES == 0) begin : g_pass
         assign sync_o = raw_i;
      end else begin : g_chain
         logic [BITS-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
               always_ff @(posedge clk) begin
                  if (!rst_n) stage_q[s] <= '1;
                  else        stage_q[s] <= raw_i;
               end
            end else begin : g_next
               always_ff @(posedge clk) begin
                  if (!rst_n) stage_q[s] <= '1;
                  else        stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign sync_o = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/kls_sched.sv
module kls_sched
   import kls_pkg::*;
#(
   parameter int WIN_LINES = 128,
   parameter int DIV_SLOW  = 4,
   parameter int DIV_FAST  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic field_tick,
   input  logic line_tick,
   input  logic rate_sel,
   output logic win_open,
   output logic win_start,
   output logic line_in_win
);

   localparam int DIV_MAX = kls_max(DIV_SLOW, DIV_FAST);
   localparam int FW      = kls_w(DIV_MAX);
   localparam int LW      = kls_w(WIN_LINES);
   localparam logic [FW-1:0] LIM_SLOW = FW'(DIV_SLOW - 1);
   localparam logic [FW-1:0] LIM_FAST = FW'(DIV_FAST - 1);
   localparam logic [LW-1:0] LAST_LN  = LW'(WIN_LINES - 1);

   initial begin
      assert (DIV_SLOW >= 1 && DIV_FAST >= 1) else $error("kls_sched: divisors must be positive");
      assert (WIN_LINES >= 1) else $error("kls_sched: WIN_LINES must be positive");
   end

   logic [FW-1:0] fcnt_q;
   logic [FW-1:0] lim;
   logic [LW-1:0] lcnt_q;
   logic          open_q;
   kls_rate_e     rate;

   assign rate = kls_rate_e'(rate_sel);
   assign lim  = (rate == RATE_FAST_FIELD) ? LIM_FAST : LIM_SLOW;

   // a field tick that finds the divider at zero starts a window
   assign win_start   = field_tick && (fcnt_q == '0);
   assign line_in_win = line_tick && open_q && !win_start;
   assign win_open    = open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fcnt_q <= '0;
      end else if (field_tick) begin
         if (fcnt_q >= lim) fcnt_q <= '0;
         else               fcnt_q <= fcnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         lcnt_q <= '0;
      end else if (win_start) begin
         open_q <= 1'b1;
         lcnt_q <= '0;
      end else if (line_in_win) begin
         if (lcnt_q == LAST_LN) begin
            open_q <= 1'b0;
            lcnt_q <= '0;
         end else begin
            lcnt_q <= lcnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/kls_pack.sv
module kls_pack
   import kls_pkg::*;
#(
   parameter int SAMPLES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   line_tick,
   input  logic                   win_start,
   input  logic                   line_in_win,
   input  logic                   clk_smp,
   input  logic                   dat_smp,
   output logic [2*SAMPLES-1:0]   byte_o,
   output logic                   valid_o
);

   localparam int CW = kls_w(SAMPLES);
   localparam logic [CW-1:0] LAST_S = CW'(SAMPLES - 1);

   initial begin
      assert (SAMPLES >= 1) else $error("kls_pack: SAMPLES must be positive");
   end

   logic [SAMPLES-1:0] clk_hist_q, dat_hist_q;
   logic [SAMPLES-1:0] clk_hist_d, dat_hist_d;
   logic [CW-1:0]      scnt_q;

   // newest sample enters at the bottom, oldest drifts to the top
   generate
      if (SAMPLES == 1) begin : g_one
         assign clk_hist_d = clk_smp;
         assign dat_hist_d = dat_smp;
      end else begin : g_many
         assign clk_hist_d = {clk_hist_q[SAMPLES-2:0], clk_smp};
         assign dat_hist_d = {dat_hist_q[SAMPLES-2:0], dat_smp};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_hist_q <= '0;
         dat_hist_q <= '0;
      end else if (line_tick) begin
         clk_hist_q <= clk_hist_d;
         dat_hist_q <= dat_hist_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scnt_q  <= '0;
         valid_o <= 1'b0;
         byte_o  <= '0;
      end else begin
         valid_o <= 1'b0;
         if (win_start) begin
            scnt_q <= '0;
         end else if (line_in_win) begin
            if (scnt_q == LAST_S) begin
               scnt_q  <= '0;
               valid_o <= 1'b1;
               byte_o  <= {clk_hist_d, dat_hist_d};
            end else begin
               scnt_q <= scnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/kbd_line_sampler.sv
module kbd_line_sampler #(
   parameter int SAMPLES     = 4,
   parameter int WIN_LINES   = 128,
   parameter int DIV_SLOW    = 4,
   parameter int DIV_FAST    = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_tick,
   input  logic                 field_tick,
   input  logic                 rate_75,
   input  logic                 kbd_clk_in,
   input  logic                 kbd_dat_in,
   output logic [2*SAMPLES-1:0] pack_byte,
   output logic                 pack_valid,
   output logic                 kbd_clk_pull_low
);

   initial begin
      assert (WIN_LINES % SAMPLES == 0)
         else $error("kbd_line_sampler: WIN_LINES must be a multiple of SAMPLES");
   end

   logic [1:0] wire_sync;
   logic       win_open, win_start, line_in_win;

   kls_sync #(.BITS(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  ({kbd_clk_in, kbd_dat_in}),
      .sync_o (wire_sync)
   );

   kls_sched #(.WIN_LINES(WIN_LINES), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_sched (
      .clk         (clk),
      .rst_n       (rst_n),
      .field_tick  (field_tick),
      .line_tick   (line_tick),
      .rate_sel    (rate_75),
      .win_open    (win_open),
      .win_start   (win_start),
      .line_in_win (line_in_win)
   );

   kls_pack #(.SAMPLES(SAMPLES)) u_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_tick   (line_tick),
      .win_start   (win_start),
      .line_in_win (line_in_win),
      .clk_smp     (wire_sync[1]),
      .dat_smp     (wire_sync[0]),
      .byte_o      (pack_byte),
      .valid_o     (pack_valid)
   );

   assign kbd_clk_pull_low = !win_open;

endmodule

// File: rtl/kls_chk.sv
module kls_chk #(
   parameter int BW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          line_tick,
   input logic          field_tick,
   input logic [BW-1:0] pack_byte,
   input logic          pack_valid,
   input logic          kbd_clk_pull_low
);

   AST_RST_STATE: assert property (@(posedge clk)
      !rst_n |=> (kbd_clk_pull_low && !pack_valid && pack_byte == '0)); // R1

   AST_RELEASE_ON_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(kbd_clk_pull_low) |-> $past(field_tick)); // R2

   AST_CLOSE_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(kbd_clk_pull_low) |-> $past(line_tick)); // R5

   AST_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !pack_valid |-> $stable(pack_byte)); // R7

   AST_VALID_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      pack_valid |-> $past(line_tick)); // R7

   AST_VALID_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      pack_valid |-> $past(!kbd_clk_pull_low)); // R8

endmodule

bind kbd_line_sampler kls_chk #(.BW(2*SAMPLES)) u_kls_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .line_tick        (line_tick),
   .field_tick       (field_tick),
   .pack_byte        (pack_byte),
   .pack_valid       (pack_valid),
   .kbd_clk_pull_low (kbd_clk_pull_low)
);

// File: tb/kbd_line_sampler_tb_top.sv
`timescale 1ns/1ps
module kbd_line_sampler_tb_top;

   localparam int WIN = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_tick = 1'b0, field_tick = 1'b0, rate_75 = 1'b0;
   logic       kbd_clk_in = 1'b1, kbd_dat_in = 1'b1;
   logic [7:0] pack_byte;
   logic       pack_valid, kbd_clk_pull_low;

   always #2.5 clk = ~clk;

   kbd_line_sampler #(.WIN_LINES(WIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .field_tick(field_tick),
      .rate_75(rate_75), .kbd_clk_in(kbd_clk_in), .kbd_dat_in(kbd_dat_in),
      .pack_byte(pack_byte), .pack_valid(pack_valid), .kbd_clk_pull_low(kbd_clk_pull_low)
   );

   int total = 0, bad = 0;
   logic [7:0] exp_q[$];

   // bench model of the window and the histories
   bit       m_open = 0;
   int       m_fcnt = 0, m_lcnt = 0, m_scnt = 0;
   logic [3:0] m_cn = 4'h0, m_dn = 4'h0;
   logic [7:0] lfsr = 8'hA5;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected bytes as strobes appear
   logic prev_vld = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pack_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected strobe", pack_byte, 0);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(pack_byte == e, "R6 packed byte", pack_byte, e);
            end
            chk(!prev_vld, "R7 strobe width", 1, 0);
         end
         prev_vld <= pack_valid;
      end
   end

   task automatic pulse_field(input string req);
      int lim;
      lim = rate_75 ? 5 : 4;
      @(negedge clk);
      field_tick = 1'b1;
      if (m_fcnt == 0) begin
         m_open = 1; m_lcnt = 0; m_scnt = 0;
      end
      m_fcnt = (m_fcnt >= lim - 1) ? 0 : m_fcnt + 1;
      @(negedge clk);
      field_tick = 1'b0;
      chk(kbd_clk_pull_low == !m_open, req, kbd_clk_pull_low, !m_open);
   endtask

   task automatic pulse_line(input logic c, input logic d, input string req);
      @(negedge clk);
      kbd_clk_in = c; kbd_dat_in = d;
      repeat (4) @(negedge clk);
      line_tick = 1'b1;
      m_cn = {m_cn[2:0], c};
      m_dn = {m_dn[2:0], d};
      if (m_open) begin
         m_scnt++;
         if (m_scnt == 4) begin
            exp_q.push_back({m_cn, m_dn});
            m_scnt = 0;
         end
         m_lcnt++;
         if (m_lcnt == WIN) m_open = 0;
      end
      @(negedge clk);
      line_tick = 1'b0;
      chk(kbd_clk_pull_low == !m_open, req, kbd_clk_pull_low, !m_open);
   endtask

   task automatic rand_line(input string req);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pulse_line(lfsr[0], lfsr[3], req);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      chk(kbd_clk_pull_low == 1'b1, "R1 pull during reset", kbd_clk_pull_low, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(kbd_clk_pull_low == 1'b1, "R1 pull after reset", kbd_clk_pull_low, 1);
      chk(pack_valid == 1'b0, "R1 strobe after reset", pack_valid, 0);
      chk(pack_byte == 8'h00, "R1 byte after reset", pack_byte, 0);

      // lines before any window: no strobe, still inhibited
      for (int i = 0; i < 5; i++) rand_line("R8 line outside window");
      chk(pack_byte == 8'h00, "R8 byte untouched outside window", pack_byte, 0);

      // first field opens (modulo 4)
      pulse_field("R3 first field opens");
      // fixed patterns: clock 1,0,1,1 data 0,0,1,0 then clock 0,1,0,0 data 1,1,0,1
      pulse_line(1, 0, "R6 pattern A");
      pulse_line(0, 0, "R6 pattern A");
      pulse_line(1, 1, "R6 pattern A");
      pulse_line(1, 0, "R6 pattern A");
      pulse_line(0, 1, "R6 pattern B");
      pulse_line(1, 1, "R6 pattern B");
      pulse_line(0, 0, "R6 pattern B");
      pulse_line(0, 1, "R5 window closes after last line");
      repeat (3) @(negedge clk);
      chk(pack_byte == 8'h4D, "R6 last byte layout", pack_byte, 8'h4D);
      for (int i = 0; i < 3; i++) rand_line("R8 line after window");

      // fields 2..4 keep inhibit, 5 reopens
      for (int i = 0; i < 3; i++) pulse_field("R9 non-window field");
      pulse_field("R3 fifth field opens");
      for (int i = 0; i < WIN; i++) rand_line("R5 second window");

      // switch to modulo 5 mid-count and cycle through several windows
      rate_75 = 1'b1;
      for (int f = 0; f < 12; f++) begin
         pulse_field(m_open ? "R4 window field at rate 75" : "R9 idle field at rate 75");
         if (m_open) begin
            for (int i = 0; i < WIN; i++) rand_line("R4 window lines");
         end else begin
            for (int i = 0; i < 2; i++) rand_line("R8 idle lines");
         end
      end

      // back to modulo 4
      rate_75 = 1'b0;
      for (int f = 0; f < 6; f++) begin
         pulse_field(m_open ? "R3 window field" : "R9 idle field");
         if (m_open) for (int i = 0; i < WIN; i++) rand_line("R7 window lines");
      end

      repeat (6) @(negedge clk);
      chk(exp_q.size() == 0, "R7 all expected strobes seen", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule